// File: doc/BRIEF.md
# NAND Page Program and Block Erase Engine

This block is the storage core of a small-page NAND flash device model. It holds a byte array organised as pages, each made of a data area followed by a spare area one thirty-second the size of the data area, with pages grouped into erase blocks. A command decoder in front of it turns host cycles into single-cycle pulses. These pulses open a program sequence, append data bytes, select an area offset, confirm a program, erase a block, or load a page into the shared page buffer for reading.

A program sequence collects bytes in the page buffer. On confirm, those bytes are merged into the chosen page by bitwise AND, so programming can only clear bits. Erase returns a whole block, data and spare, to all-ones. Load copies the tail of a page, from a chosen starting byte, into the buffer. The host then reads the buffer through an index port. The engine works on one byte per clock and runs one operation at a time. It shows `busy` for the whole operation and a one-cycle `done` at its end.

Top module: `nand_page_engine`

## Requirements
- R1: After reset every array byte, data and spare, reads as 0xFF, and `busy` and `done` are low.
- R2: A `setup_pulse` empties the page buffer. Each later `data_we` byte is appended in arrival order until the buffer holds a full page plus spare (ROW bytes). Bytes beyond that are ignored.
- R3: On `prog_req`, the buffered bytes are ANDed into page `page_sel` from byte `col_sel + area offset` onward. Bytes that would land past the end of the page's spare area are dropped. A stored 0 bit never becomes 1.
- R4: With `wp_n` low at the request, program and erase requests are ignored: `busy` stays low and the array is unchanged. Loads are unaffected.
- R5: An `area_we` pulse sets an area offset that is added to `col_sel` for both program and load. A program that executes resets the area offset to 0. A load leaves it unchanged.
- R6: For erase, the page index is `erase_raw` masked to its low 8×`erase_nbytes` bits (0 bytes gives page 0). The index is rounded down to a multiple of PAGES_PER_BLK. Every byte of that block becomes 0xFF.
- R7: A program, erase or load whose page index is at or above the page count is ignored: no `busy`, no `done`, and no change to the array or buffer.
- R8: A load writes page bytes from the starting byte to the end of the spare area into buffer positions 0 onward. These are readable on `rd_data` at index `rd_idx`.
- R9: An accepted operation of L byte steps raises `busy` from the next cycle. `done` is high for exactly one cycle, L+1 cycles after acceptance. `busy` falls in the cycle after `done`. An empty program takes no byte steps.
- R10: While `busy` is high, all requests, `setup_pulse`, `data_we` and `area_we` are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write protect, active low |
| setup_pulse | input | 1 | Start a program sequence (empty the buffer) |
| data_we | input | 1 | Append `data_byte` to the buffer |
| data_byte | input | 8 | Program data byte |
| area_we | input | 1 | Load the area offset |
| area_val | input | 7 | Area offset value |
| prog_req | input | 1 | Confirm program of the buffer into a page |
| load_req | input | 1 | Load a page into the buffer |
| page_sel | input | 5 | Page index for program and load |
| col_sel | input | 7 | Starting column for program and load |
| erase_req | input | 1 | Erase the block holding the addressed page |
| erase_raw | input | 24 | Raw gathered erase address bytes |
| erase_nbytes | input | 2 | Number of erase address bytes received |
| rd_idx | input | 7 | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_idx` (0 past the end) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench uses 64-byte pages with 2 spare bytes, 4 pages per block and 2 blocks, giving 8 pages and 528 array bytes. Every page can then be read back in full after each directed case and at the end of the random phase. An 8-page space lets one-byte erase addresses above and below the page count be tried directly. It also lets a page index of exactly the page count be reached. The 66-byte row makes buffer overflow, spare-area programming and clipping at the row end short to reach.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_LOAD  = 3'd3,
    ST_FIN   = 3'd4
  } eng_state_e;

  // keep only the address bytes actually received
  function automatic logic [23:0] keep_bytes(input logic [23:0] raw, input logic [1:0] nbytes);
    logic [23:0] r;
    case (nbytes)
      2'd0:    r = 24'h000000;
      2'd1:    r = {16'h0000, raw[7:0]};
      2'd2:    r = {8'h00, raw[15:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
  parameter int unsigned CELLS = 1056,
  parameter int unsigned AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          set_ones,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);

  logic [7:0] cells_q [CELLS];
  logic [7:0] wr_val;

  assign dout = cells_q[addr];

  always_comb begin
    wr_val = set_ones ? 8'hFF : (cells_q[addr] & din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(CELLS); i++) cells_q[i] <= 8'hFF;
    end else if (we) begin
      cells_q[addr] <= wr_val;
    end
  end

  // R6
  arr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (32'(addr) < CELLS));

endmodule

// File: rtl/nand_page_buffer.sv
module nand_page_buffer #(
  parameter int unsigned ROW   = 66,
  parameter int unsigned ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             setup,
  input  logic             app_we,
  input  logic [7:0]       app_data,
  input  logic             ld_we,
  input  logic [ROW_W-1:0] idx,
  input  logic [7:0]       ld_data,
  output logic [7:0]       prg_data,
  input  logic [ROW_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [ROW_W-1:0] fill
);

  logic [7:0]       bytes_q [ROW];
  logic [ROW_W-1:0] fill_q, fill_d;
  logic             fill_en, app_en;

  assign app_en = !busy && !setup && app_we && (32'(fill_q) < ROW);

  always_comb begin
    fill_d  = fill_q;
    fill_en = 1'b0;
    if (!busy && setup) begin
      fill_d  = '0;
      fill_en = 1'b1;
    end else if (app_en) begin
      fill_d  = fill_q + 1'b1;
      fill_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (ld_we)       bytes_q[idx]    <= ld_data;
    else if (app_en) bytes_q[fill_q] <= app_data;
  end

  assign fill     = fill_q;
  assign prg_data = bytes_q[idx];
  assign rd_data  = (32'(rd_idx) < ROW) ? bytes_q[rd_idx] : 8'h00;

  // R2
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_q) <= ROW);

  // R10
  fill_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fill_q));

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
  import nand_eng_pkg::*;
#(
  parameter int unsigned ROW       = 66,
  parameter int unsigned ROW_W     = 7,
  parameter int unsigned PPB       = 4,
  parameter int unsigned NUM_PAGES = 16,
  parameter int unsigned PG_W      = 5,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             prog_req,
  input  logic             load_req,
  input  logic             erase_req,
  input  logic [PG_W-1:0]  page_sel,
  input  logic [ROW_W-1:0] col_sel,
  input  logic [23:0]      erase_raw,
  input  logic [1:0]       erase_nbytes,
  input  logic             area_we,
  input  logic [ROW_W-1:0] area_val,
  input  logic [ROW_W-1:0] fill,
  output logic [ADDR_W-1:0] arr_addr,
  output logic             arr_we,
  output logic             arr_ones,
  output logic             buf_ld_we,
  output logic [ROW_W-1:0] buf_idx,
  output logic             busy,
  output logic             done
);

  localparam int unsigned BLK_BYTES = PPB * ROW;
  localparam logic [ROW_W:0] ROW_V  = (ROW_W+1)'(ROW);

  eng_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_q, last_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ROW_W-1:0]  area_q, area_d;

  logic [ROW_W:0] offs, room, prog_len;
  logic           page_ok, er_ok;
  logic [31:0]    page_base, er_page, er_base;

  always_comb begin
    offs      = {1'b0, col_sel} + {1'b0, area_q};
    room      = (offs >= ROW_V) ? '0 : (ROW_V - offs);
    prog_len  = ({1'b0, fill} < room) ? {1'b0, fill} : room;
    page_ok   = 32'(page_sel) < NUM_PAGES;
    page_base = 32'(page_sel) * ROW + 32'(offs);
    er_page   = 32'(keep_bytes(erase_raw, erase_nbytes));
    er_ok     = er_page < NUM_PAGES;
    er_base   = (er_page / PPB) * BLK_BYTES;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    base_d = base_q;
    area_d = area_q;
    case (st_q)
      ST_IDLE: begin
        if (area_we) area_d = area_val;
        if (erase_req) begin
          if (wp_n && er_ok) begin
            st_d   = ST_ERASE;
            cnt_d  = '0;
            base_d = ADDR_W'(er_base);
            last_d = CNT_W'(BLK_BYTES - 1);
          end
        end else if (prog_req) begin
          if (wp_n && page_ok) begin
            area_d = '0;
            cnt_d  = '0;
            base_d = ADDR_W'(page_base);
            last_d = CNT_W'(32'(prog_len) - 1);
            st_d   = (prog_len == '0) ? ST_FIN : ST_PROG;
          end
        end else if (load_req) begin
          if (page_ok) begin
            cnt_d  = '0;
            base_d = ADDR_W'(page_base);
            last_d = CNT_W'(32'(room) - 1);
            st_d   = (room == '0) ? ST_FIN : ST_LOAD;
          end
        end
      end
      ST_PROG, ST_ERASE, ST_LOAD: begin
        if (cnt_q == last_q) st_d = ST_FIN;
        else                 cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      area_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      base_q <= base_d;
      area_q <= area_d;
    end
  end

  assign arr_addr  = ADDR_W'(32'(base_q) + 32'(cnt_q));
  assign arr_we    = (st_q == ST_PROG) || (st_q == ST_ERASE);
  assign arr_ones  = (st_q == ST_ERASE);
  assign buf_ld_we = (st_q == ST_LOAD);
  assign buf_idx   = cnt_q[ROW_W-1:0];
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R4
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !erase_req && prog_req && !wp_n) |=> !busy);

  // R7
  load_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !erase_req && !prog_req && load_req && (32'(page_sel) >= NUM_PAGES)) |=> !busy);

  // R5
  area_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !erase_req && prog_req && wp_n && (32'(page_sel) < NUM_PAGES)) |=> (area_q == '0));

endmodule

// File: rtl/nand_page_engine.sv
module nand_page_engine #(
  parameter int unsigned PAGE_BYTES    = 64,
  parameter int unsigned PAGES_PER_BLK = 4,
  parameter int unsigned NUM_BLOCKS    = 4,
  localparam int unsigned SPARE_BYTES  = PAGE_BYTES / 32,
  localparam int unsigned ROW          = PAGE_BYTES + SPARE_BYTES,
  localparam int unsigned NUM_PAGES    = PAGES_PER_BLK * NUM_BLOCKS,
  localparam int unsigned ROW_W        = $clog2(ROW + 1),
  localparam int unsigned PG_W         = $clog2(NUM_PAGES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             setup_pulse,
  input  logic             data_we,
  input  logic [7:0]       data_byte,
  input  logic             area_we,
  input  logic [ROW_W-1:0] area_val,
  input  logic             prog_req,
  input  logic             load_req,
  input  logic [PG_W-1:0]  page_sel,
  input  logic [ROW_W-1:0] col_sel,
  input  logic             erase_req,
  input  logic [23:0]      erase_raw,
  input  logic [1:0]       erase_nbytes,
  input  logic [ROW_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done
);

  localparam int unsigned CELLS  = NUM_PAGES * ROW;
  localparam int unsigned ADDR_W = $clog2(CELLS);
  localparam int unsigned CNT_W  = $clog2(PAGES_PER_BLK * ROW + 1);

  logic [ADDR_W-1:0] arr_addr;
  logic              arr_we, arr_ones, buf_ld_we;
  logic [ROW_W-1:0]  buf_idx, fill;
  logic [7:0]        arr_dout, prg_data;

  nand_op_sequencer #(
    .ROW(ROW), .ROW_W(ROW_W), .PPB(PAGES_PER_BLK), .NUM_PAGES(NUM_PAGES),
    .PG_W(PG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .prog_req(prog_req), .load_req(load_req), .erase_req(erase_req),
    .page_sel(page_sel), .col_sel(col_sel),
    .erase_raw(erase_raw), .erase_nbytes(erase_nbytes),
    .area_we(area_we), .area_val(area_val), .fill(fill),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_ones(arr_ones),
    .buf_ld_we(buf_ld_we), .buf_idx(buf_idx), .busy(busy), .done(done)
  );

  nand_page_buffer #(.ROW(ROW), .ROW_W(ROW_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .busy(busy), .setup(setup_pulse),
    .app_we(data_we), .app_data(data_byte),
    .ld_we(buf_ld_we), .idx(buf_idx), .ld_data(arr_dout), .prg_data(prg_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .fill(fill)
  );

  nand_cell_array #(.CELLS(CELLS), .AW(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .set_ones(arr_ones),
    .addr(arr_addr), .din(prg_data), .dout(arr_dout)
  );

endmodule

// File: tb/nand_page_engine_bench.sv
module nand_page_engine_bench;

  localparam int PB = 64, PPB = 4, NB = 2;
  localparam int SP = PB / 32, ROW = PB + SP, NP = PPB * NB, TOT = NP * ROW;
  localparam int ROW_W = $clog2(ROW + 1), PG_W = $clog2(NP) + 1;

  logic clk, rst_n, wp_n, setup_pulse, data_we, area_we, prog_req, load_req, erase_req;
  logic [7:0] data_byte, rd_data;
  logic [ROW_W-1:0] area_val, col_sel, rd_idx;
  logic [PG_W-1:0] page_sel;
  logic [23:0] erase_raw;
  logic [1:0] erase_nbytes;
  logic busy, done;

  nand_page_engine #(.PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .NUM_BLOCKS(NB)) u_nand_page_engine (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .setup_pulse(setup_pulse),
    .data_we(data_we), .data_byte(data_byte), .area_we(area_we), .area_val(area_val),
    .prog_req(prog_req), .load_req(load_req), .page_sel(page_sel), .col_sel(col_sel),
    .erase_req(erase_req), .erase_raw(erase_raw), .erase_nbytes(erase_nbytes),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] model [TOT];
  logic [7:0] mbuf [ROW];
  int mfill, marea, checks, fails;
  bit finished;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int keep(input int raw, input int nb);
    if (nb == 0) return 0;
    if (nb == 1) return raw & 32'hFF;
    if (nb == 2) return raw & 32'hFFFF;
    return raw & 32'hFFFFFF;
  endfunction

  task automatic do_setup();
    @(negedge clk); setup_pulse = 1'b1;
    @(negedge clk); setup_pulse = 1'b0;
    mfill = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; data_byte = b;
    @(negedge clk); data_we = 1'b0;
    if (mfill < ROW) begin mbuf[mfill] = b; mfill++; end
  endtask

  task automatic set_area(input int v);
    @(negedge clk); area_we = 1'b1; area_val = ROW_W'(v);
    @(negedge clk); area_we = 1'b0;
    marea = v;
  endtask

  // kind 0 program, 1 erase, 2 load
  task automatic run_op(input int kind, input int page, input int col, input int raw,
                        input int nb, input string req);
    int offs, room, len, base, pg, n;
    bit ok;
    offs = col + marea;
    room = (offs >= ROW) ? 0 : ROW - offs;
    ok = 0; len = 0; base = 0;
    if (kind == 0) begin
      ok = wp_n && (page < NP);
      len = (mfill < room) ? mfill : room;
      if (ok) begin
        for (int i = 0; i < len; i++) model[page*ROW+offs+i] &= mbuf[i];
        marea = 0;
      end
    end else if (kind == 1) begin
      pg = keep(raw, nb);
      ok = wp_n && (pg < NP);
      len = PPB * ROW;
      base = (pg / PPB) * PPB * ROW;
      if (ok) for (int i = 0; i < len; i++) model[base+i] = 8'hFF;
    end else begin
      ok = (page < NP);
      len = room;
      if (ok) for (int i = 0; i < len; i++) mbuf[i] = model[page*ROW+offs+i];
    end
    @(negedge clk);
    page_sel = PG_W'(page); col_sel = ROW_W'(col);
    erase_raw = 24'(raw); erase_nbytes = 2'(nb);
    prog_req = (kind == 0); erase_req = (kind == 1); load_req = (kind == 2);
    @(negedge clk);
    prog_req = 1'b0; erase_req = 1'b0; load_req = 1'b0;
    chk(busy == ok, req, "busy after request", busy, ok);
    if (ok) begin
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(n == len, req, "cycles to done", n, len);
      @(negedge clk);
      chk(!busy && !done, req, "idle after done", busy, 0);
      if (kind == 2) begin
        for (int i = 0; i < len; i++) begin
          rd_idx = ROW_W'(i); #1;
          chk(rd_data == mbuf[i], req, $sformatf("buffer byte %0d", i), rd_data, mbuf[i]);
        end
      end
    end else begin
      @(negedge clk);
      chk(!busy && !done, req, "ignored request stays idle", busy, 0);
    end
  endtask

  task automatic verify_page(input int p, input string req);
    if (marea != 0) set_area(0);
    run_op(2, p, 0, 0, 0, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    checks = 0; fails = 0; finished = 0; mfill = 0; marea = 0;
    for (int i = 0; i < TOT; i++) model[i] = 8'hFF;
    rst_n = 1'b0; wp_n = 1'b1; setup_pulse = 0; data_we = 0; data_byte = 0;
    area_we = 0; area_val = 0; prog_req = 0; load_req = 0; erase_req = 0;
    page_sel = 0; col_sel = 0; erase_raw = 0; erase_nbytes = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", busy, 0);
    for (int p = 0; p < NP; p++) verify_page(p, "R1");

    // R2 R3: ordered append and AND merge at a column
    do_setup();
    send_byte(8'hF0); send_byte(8'h0F); send_byte(8'hAA); send_byte(8'h55);
    run_op(0, 1, 3, 0, 0, "R3");
    verify_page(1, "R2");
    do_setup();
    send_byte(8'hFF); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    run_op(0, 1, 3, 0, 0, "R3");
    verify_page(1, "R3");
    rd_idx = ROW_W'(3); #1;
    chk(rd_data == 8'hF0, "R3", "zero bits not raised", rd_data, 8'hF0);

    // R2 buffer cap
    do_setup();
    for (int i = 0; i < ROW + 3; i++) send_byte(8'(i ^ 8'h5A));
    run_op(0, 2, 0, 0, 0, "R2");
    verify_page(2, "R2");

    // R3 clip at row end
    do_setup();
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    run_op(0, 0, ROW - 2, 0, 0, "R3");
    verify_page(0, "R3");
    verify_page(1, "R3");

    // R5 area offset into spare, then cleared
    set_area(PB);
    do_setup(); send_byte(8'h81); send_byte(8'h42);
    run_op(0, 3, 0, 0, 0, "R5");
    do_setup(); send_byte(8'h00);
    run_op(0, 3, 0, 0, 0, "R5");
    verify_page(3, "R5");
    set_area(10);
    run_op(2, 3, 5, 0, 0, "R5");
    run_op(2, 3, 0, 0, 0, "R5");
    set_area(0);

    // R4 write protect
    wp_n = 1'b0;
    do_setup(); send_byte(8'h00);
    run_op(0, 0, 0, 0, 0, "R4");
    run_op(1, 0, 0, 1, 1, "R4");
    run_op(2, 1, 0, 0, 0, "R4");
    wp_n = 1'b1;
    verify_page(0, "R4");
    verify_page(1, "R4");

    // R7 out of range
    do_setup(); send_byte(8'h00);
    run_op(0, NP, 0, 0, 0, "R7");
    run_op(1, 0, 0, NP, 1, "R7");
    run_op(2, NP, 0, 0, 0, "R7");
    run_op(2, (1 << PG_W) - 1, 0, 0, 0, "R7");

    // R6 erase masking and alignment
    do_setup(); send_byte(8'h00); send_byte(8'h01);
    run_op(0, 6, 7, 0, 0, "R6");
    run_op(1, 0, 0, 24'h000105, 2, "R6");
    run_op(1, 0, 0, 24'h000105, 1, "R6");
    verify_page(6, "R6");
    verify_page(4, "R6");
    run_op(1, 0, 0, 24'hFFFFFF, 0, "R6");
    verify_page(1, "R6");
    verify_page(2, "R6");

    // R10 drops while busy; R9 empty program
    do_setup(); send_byte(8'h0F); send_byte(8'hF0); send_byte(8'h66);
    @(negedge clk); erase_raw = 24'd0; erase_nbytes = 2'd1; erase_req = 1'b1;
    @(negedge clk); erase_req = 1'b0;
    for (int i = 0; i < PPB * ROW; i++) model[i] = 8'hFF;
    @(negedge clk);
    setup_pulse = 1'b1; data_we = 1'b1; data_byte = 8'h00; area_we = 1'b1;
    area_val = ROW_W'(20); load_req = 1'b1; page_sel = 0;
    @(negedge clk);
    setup_pulse = 0; data_we = 0; area_we = 0; load_req = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R10", "request during busy dropped", busy, 0);
    run_op(0, 0, 0, 0, 0, "R10");
    verify_page(0, "R10");
    do_setup();
    run_op(0, 5, 0, 0, 0, "R9");

    // random phase
    for (int it = 0; it < 60; it++) begin
      int k;
      k = $urandom_range(0, 9);
      wp_n = ($urandom_range(0, 7) != 0);
      if (k < 3) begin
        do_setup();
        for (int j = 0, m = $urandom_range(0, 8); j < m; j++) send_byte(8'($urandom));
        if ($urandom_range(0, 3) == 0) set_area($urandom_range(0, ROW + 2));
        run_op(0, $urandom_range(0, NP), $urandom_range(0, ROW - 1), 0, 0, "R3");
      end else if (k < 5) begin
        run_op(1, 0, 0, $urandom_range(0, 2 * NP), $urandom_range(0, 3), "R6");
      end else begin
        run_op(2, $urandom_range(0, NP), $urandom_range(0, ROW - 1), 0, 0, "R8");
      end
    end
    wp_n = 1'b1;
    for (int p = 0; p < NP; p++) verify_page(p, "R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule